// File: doc/BRIEF.md
# Multiplexed LCD Segment Output Mapper

This block turns one row of display data into drive-level choices for forty LCD segment pins. For every pin it produces a 2-bit code naming the supply or bias rail that the analog switches should connect: the ground rail, one of two intermediate bias levels, or the LCD supply. The analog bias network and the switches are not part of this block.

In row-and-column mode, the lowest pins act as row commons and the rest act as columns. The number of row pins follows the multiplex ratio: 2, 4 or 8. A column-only input turns every pin into a column, which lets the block drive one part of a larger cascaded panel. Column and row pins move in opposite directions against the frame polarity input. Two override inputs force every column on or off. Codes are captured once per frame-polarity transition, so the pins hold steady for a whole polarity half-period.

All pins are plain level or control signals. Data is taken whenever FR changes, so there is no valid/ready handshake and no back-pressure. The upstream sequencer must hold the row word, row index and mode inputs valid on the clock at which a new FR level is first seen.

Top module: `lcd_seg_mapper`

## Requirements
- R1: While reset is asserted and until the first FR transition after it, every output code is 00.
- R2: Output codes change only on the first clock edge at which the sampled FR differs from its value at the previous edge (either direction). Otherwise they hold, whatever the other inputs do.
- R3: Each output k takes bits [2k+1:2k] of seg_code, encoded 00 = VSS, 01 = V1, 10 = V2, 11 = VLCD.
- R4: A column output k takes bit k of row_word. A 1 (on) gives 00 when FR is 1 and 11 when FR is 0. A 0 (off) gives 11 when FR is 1 and 00 when FR is 0.
- R5: With col_only low, mux_sel 00 makes outputs 0..1 rows, 01 makes outputs 0..3 rows, and 11 or 10 makes outputs 0..7 rows. All higher outputs are columns.
- R6: The selected row is row_idx modulo the row count. It drives 11 when FR is 1 and 00 when FR is 0.
- R7: Every unselected row drives 01 when FR is 1 and 10 when FR is 0.
- R8: With col_only high, all 40 outputs follow R4, and mux_sel and row_idx have no effect.
- R9: Bits of row_word that lie under row outputs have no effect.
- R10: force_on makes every column output behave as data 1.
- R11: force_off makes every column output behave as data 0, and it wins over force_on.
- R12: force_on and force_off leave row outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr | input | 1 | Frame polarity level |
| mux_sel | input | 2 | Multiplex ratio select |
| col_only | input | 1 | All outputs act as columns |
| force_on | input | 1 | Force all columns on |
| force_off | input | 1 | Force all columns off |
| row_idx | input | 3 | Index of the active row |
| row_word | input | 40 | Pixel data of the active row, bit k for output k |
| seg_code | output | 80 | Level codes, 2 bits per output |

## Verification
A new FR level driven between clock edges is seen at the next rising edge. At that same edge the codes built from the inputs present then are registered, so each result is due one edge after the stimulus. The bench drives inputs on the falling edge, updates its expected vector only when the FR level it drives differs from the one it drove at the previous edge, and compares on the next falling edge. Steps with no FR change check that the codes hold, even though the other inputs were changed.

// File: rtl/lcdmap_pkg.sv
package lcdmap_pkg;
  typedef enum logic [1:0] {
    LVL_VSS  = 2'b00,
    LVL_V1   = 2'b01,
    LVL_V2   = 2'b10,
    LVL_VLCD = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    MUX_2   = 2'b00,
    MUX_4   = 2'b01,
    MUX_RSV = 2'b10,
    MUX_8   = 2'b11
  } mux_e;

  // number of row commons for a mux select code (reserved code acts as 8)
  function automatic logic [3:0] mux_rows(input logic [1:0] sel);
    case (sel)
      MUX_2:   mux_rows = 4'd2;
      MUX_4:   mux_rows = 4'd4;
      default: mux_rows = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/lcdmap_fr_edge.sv
module lcdmap_fr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic fr,
  output logic fr_edge
);
  logic fr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) fr_q <= 1'b0;
    else        fr_q <= fr;
  end

  assign fr_edge = fr ^ fr_q;
endmodule

// File: rtl/lcdmap_row_plan.sv
module lcdmap_row_plan
  import lcdmap_pkg::*;
#(
  parameter int NUM_SEG  = 40,
  parameter int MAX_ROWS = 8,
  localparam int IDX_W   = $clog2(MAX_ROWS)
) (
  input  logic [1:0]       mux_sel,
  input  logic             col_only,
  input  logic [IDX_W-1:0] row_idx,
  output logic [NUM_SEG-1:0] is_row,
  output logic [NUM_SEG-1:0] row_hit
);
  logic [3:0]       n_rows;
  logic [IDX_W-1:0] idx_wrap;
  logic [IDX_W-1:0] idx_mask;

  always_comb begin
    n_rows   = mux_rows(mux_sel);
    idx_mask = IDX_W'(n_rows - 4'd1);
    idx_wrap = row_idx & idx_mask;
  end

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_pin
    if (k < MAX_ROWS) begin : g_cand
      always_comb begin
        is_row[k]  = !col_only && (4'(k) < n_rows);
        row_hit[k] = is_row[k] && (idx_wrap == IDX_W'(k));
      end
    end else begin : g_col
      always_comb begin
        is_row[k]  = 1'b0;
        row_hit[k] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lcdmap_seg_level.sv
module lcdmap_seg_level
  import lcdmap_pkg::*;
(
  input  logic       is_row,
  input  logic       row_hit,
  input  logic       col_on,
  input  logic       fr,
  output logic [1:0] level
);
  always_comb begin
    if (is_row) begin
      if (row_hit) level = fr ? LVL_VLCD : LVL_VSS;
      else         level = fr ? LVL_V1   : LVL_V2;
    end else begin
      if (col_on)  level = fr ? LVL_VSS  : LVL_VLCD;
      else         level = fr ? LVL_VLCD : LVL_VSS;
    end
  end
endmodule

// File: rtl/lcd_seg_mapper.sv
module lcd_seg_mapper
  import lcdmap_pkg::*;
#(
  parameter int NUM_SEG  = 40,
  parameter int MAX_ROWS = 8,
  localparam int IDX_W   = $clog2(MAX_ROWS),
  localparam int CODE_W  = 2 * NUM_SEG
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fr,
  input  logic [1:0]         mux_sel,
  input  logic               col_only,
  input  logic               force_on,
  input  logic               force_off,
  input  logic [IDX_W-1:0]   row_idx,
  input  logic [NUM_SEG-1:0] row_word,
  output logic [CODE_W-1:0]  seg_code
);
  logic               fr_edge;
  logic [NUM_SEG-1:0] is_row;
  logic [NUM_SEG-1:0] row_hit;
  logic [CODE_W-1:0]  code_next;
  logic [CODE_W-1:0]  code_q;

  lcdmap_fr_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .fr      (fr),
    .fr_edge (fr_edge)
  );

  lcdmap_row_plan #(.NUM_SEG(NUM_SEG), .MAX_ROWS(MAX_ROWS)) u_plan (
    .mux_sel  (mux_sel),
    .col_only (col_only),
    .row_idx  (row_idx),
    .is_row   (is_row),
    .row_hit  (row_hit)
  );

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    logic col_on;
    // blank wins over set, set wins over data
    assign col_on = !force_off && (force_on || row_word[k]);

    lcdmap_seg_level u_lvl (
      .is_row  (is_row[k]),
      .row_hit (row_hit[k]),
      .col_on  (col_on),
      .fr      (fr),
      .level   (code_next[2*k+1:2*k])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       code_q <= '0;
    else if (fr_edge) code_q <= code_next;
  end

  assign seg_code = code_q;
endmodule

// File: rtl/lcd_seg_mapper_chk.sv
module lcd_seg_mapper_chk #(
  parameter int NUM_SEG  = 40,
  parameter int MAX_ROWS = 8,
  localparam int IDX_W   = $clog2(MAX_ROWS),
  localparam int CODE_W  = 2 * NUM_SEG
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fr,
  input logic [1:0]         mux_sel,
  input logic               col_only,
  input logic               force_on,
  input logic               force_off,
  input logic [IDX_W-1:0]   row_idx,
  input logic [NUM_SEG-1:0] row_word,
  input logic [CODE_W-1:0]  seg_code
);
  logic               fr_d;
  logic               fr_chg;
  logic [NUM_SEG-1:0] mid_mask;
  logic [7:0]         mid_cnt;
  logic [7:0]         unsel_rows;

  always_ff @(posedge clk) begin
    if (!rst_n) fr_d <= 1'b0;
    else        fr_d <= fr;
  end

  always_comb begin
    fr_chg = fr != fr_d;
    for (int k = 0; k < NUM_SEG; k++)
      mid_mask[k] = seg_code[2*k+1] ^ seg_code[2*k];
    mid_cnt = 8'($countones(mid_mask));
    case (mux_sel)
      2'b00:   unsel_rows = 8'd1;
      2'b01:   unsel_rows = 8'd3;
      default: unsel_rows = 8'd7;
    endcase
  end

  a_r2_hold_without_fr_change: assert property (@(posedge clk) disable iff (!rst_n)
    !fr_chg |=> $stable(seg_code));

  a_r8_col_only_no_mid_levels: assert property (@(posedge clk) disable iff (!rst_n)
    fr_chg && col_only |=> mid_cnt == 8'd0);

  a_r7_unselected_rows_mid: assert property (@(posedge clk) disable iff (!rst_n)
    fr_chg && !col_only |=> mid_cnt == $past(unsel_rows));

  a_r11_blank_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    fr_chg && col_only && force_off |=> seg_code == {NUM_SEG{$past(fr), $past(fr)}});

  a_r10_set_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    fr_chg && col_only && force_on && !force_off |=> seg_code == {NUM_SEG{!$past(fr), !$past(fr)}});
endmodule

bind lcd_seg_mapper lcd_seg_mapper_chk #(.NUM_SEG(NUM_SEG), .MAX_ROWS(MAX_ROWS)) u_chk (.*);

// File: tb/lcd_seg_mapper_tb.sv
module lcd_seg_mapper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSEG = 40;
  localparam int CW = 2 * NSEG;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fr = 1'b0;
  logic [1:0]    mux_sel = 2'b00;
  logic          col_only = 1'b0;
  logic          force_on = 1'b0;
  logic          force_off = 1'b0;
  logic [2:0]    row_idx = 3'd0;
  logic [NSEG-1:0] row_word = '0;
  logic [CW-1:0] seg_code;

  int checks = 0;
  int failures = 0;
  logic          fr_last = 1'b0;
  logic [CW-1:0] exp_q = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_seg_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .fr(fr), .mux_sel(mux_sel), .col_only(col_only),
    .force_on(force_on), .force_off(force_off), .row_idx(row_idx),
    .row_word(row_word), .seg_code(seg_code)
  );

  function automatic logic [CW-1:0] model(
    input logic [NSEG-1:0] w, input logic [2:0] idx, input logic [1:0] mx,
    input logic co, input logic son, input logic soff, input logic f);
    logic [CW-1:0] r;
    int n;
    logic on;
    n = (mx == 2'b00) ? 2 : (mx == 2'b01) ? 4 : 8;
    for (int k = 0; k < NSEG; k++) begin
      if (!co && k < n) begin
        if (k == int'(idx) % n) r[2*k +: 2] = f ? 2'b11 : 2'b00;
        else                    r[2*k +: 2] = f ? 2'b01 : 2'b10;
      end else begin
        on = soff ? 1'b0 : (son ? 1'b1 : w[k]);
        r[2*k +: 2] = (on ^ f) ? 2'b11 : 2'b00;
      end
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [CW-1:0] act, input logic [CW-1:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // called at a falling edge: drive current values, then compare one edge later
  task automatic step(input string tag);
    if (fr != fr_last)
      exp_q = model(row_word, row_idx, mux_sel, col_only, force_on, force_off, fr);
    fr_last = fr;
    @(posedge clk);
    @(negedge clk);
    chk(seg_code === exp_q, tag, seg_code, exp_q);
  endtask

  task automatic setup(input logic [NSEG-1:0] w, input logic [2:0] idx, input logic [1:0] mx,
                       input logic co, input logic son, input logic soff);
    row_word = w; row_idx = idx; mux_sel = mx; col_only = co; force_on = son; force_off = soff;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (4) @(negedge clk);
    chk(seg_code === '0, "R1 reset", seg_code, '0);
    rst_n = 1'b1;
    setup({NSEG{1'b1}}, 3'd0, 2'b11, 1'b0, 1'b0, 1'b0);
    step("R1 held without FR change");

    // R3 R6 R7: mux 8, row 3 selected, FR high
    setup('0, 3'd3, 2'b11, 1'b0, 1'b0, 1'b0);
    fr = 1'b1; step("R6 R7 mux8 FR1");
    chk(seg_code[7:6] === 2'b11 && seg_code[1:0] === 2'b01 && seg_code[17:16] === 2'b11,
        "R3 literal codes FR1", seg_code, exp_q);
    fr = 1'b0; step("R6 R7 mux8 FR0");
    chk(seg_code[7:6] === 2'b00 && seg_code[1:0] === 2'b10, "R3 literal codes FR0", seg_code, exp_q);

    // R5 mux ratios and row index wrap
    setup({NSEG{1'b1}}, 3'd5, 2'b00, 1'b0, 1'b0, 1'b0);
    fr = 1'b1; step("R5 mux2 wrap");
    setup({NSEG{1'b1}}, 3'd6, 2'b01, 1'b0, 1'b0, 1'b0);
    fr = 1'b0; step("R5 mux4 wrap");
    setup({NSEG{1'b1}}, 3'd7, 2'b10, 1'b0, 1'b0, 1'b0);
    fr = 1'b1; step("R5 reserved as mux8");

    // R4 columns, R9 bits under rows ignored
    setup(40'h00_0000_00FF, 3'd1, 2'b11, 1'b0, 1'b0, 1'b0);
    fr = 1'b0; step("R9 row-position bits ignored");
    setup(40'hA5_5AF0_0F00, 3'd1, 2'b00, 1'b0, 1'b0, 1'b0);
    fr = 1'b1; step("R4 column data FR1");
    chk(seg_code[17:16] === 2'b00 && seg_code[9:8] === 2'b11, "R4 literal column", seg_code, exp_q);

    // R2 data changes without FR change
    setup(40'h12_3456_789A, 3'd2, 2'b01, 1'b1, 1'b1, 1'b0);
    step("R2 hold on data change");

    // R8 column only
    fr = 1'b0; step("R8 col_only");
    chk(seg_code[1:0] === 2'b11, "R8 output 0 is column", seg_code, exp_q);

    // R10 R11 R12 overrides
    setup(40'h0, 3'd0, 2'b01, 1'b0, 1'b1, 1'b0);
    fr = 1'b1; step("R10 set forces on R12 rows kept");
    setup({NSEG{1'b1}}, 3'd2, 2'b01, 1'b0, 1'b0, 1'b1);
    fr = 1'b0; step("R11 blank forces off R12 rows kept");
    setup(40'h5A, 3'd0, 2'b11, 1'b1, 1'b1, 1'b1);
    fr = 1'b1; step("R11 blank beats set");
    chk(seg_code === {NSEG{2'b11}}, "R11 literal all off FR1", seg_code, {NSEG{2'b11}});

    // random mix
    for (int i = 0; i < 3000; i++) begin
      string tag;
      logic nf;
      setup({8'($urandom()), 32'($urandom())}, 3'($urandom()), 2'($urandom()),
            ($urandom() % 4) == 0, ($urandom() % 5) == 0, ($urandom() % 7) == 0);
      nf = (($urandom() % 3) == 0) ? !fr : fr;
      fr = nf;
      if (fr == fr_last)  tag = "R2 random hold";
      else if (col_only)  tag = "R8 random col_only";
      else                tag = "R4 random row mode";
      step(tag);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule